// File: doc/BRIEF.md
# Power-fail store and recall controller

This controller manages a battery-free nonvolatile memory made of a fast volatile SRAM and a shadow nonvolatile array. It watches a supply-low comparator input. When the supply drops below the switch threshold, it saves the SRAM contents into the shadow array. A save is an erase phase followed by a program phase. When the supply comes back, it copies the shadow array into the SRAM. That copy is called a recall. While a transfer runs, or while the supply is low, every SRAM access is blocked.

Two refinements keep the array healthy and the data consistent. A dirty flag records whether any write was accepted since the last save or recall, and a save is skipped when the SRAM is clean. After a recall, a write strobe that is already held active is not honoured. Either the chip enable or the write enable must first go inactive, and only then will a write be accepted.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: `supply_low_i` passes through a two-flop synchroniser, and the state machine acts on it at the third rising edge after the input changes. Out of reset, `inhibit_o` is 1, no phase output is active, and nothing happens until the supply is reported good.
- R2: A recall lasts exactly `RECALL_CYC` cycles with `recall_o` high. `recall_done_o` is high only in its last cycle, `inhibit_o` stays high throughout, and `inhibit_o` goes low in the cycle after the recall ends.
- R3: `wr_en_o` is 1 exactly when `inhibit_o` is 0, both `ce_n_i` and `we_n_i` are low (active-low), and the write is armed. `wr_en_o` is never 1 while `inhibit_o` is 1.
- R4: Suppose the strobes were active in the last inhibited cycle and are still active when inhibit falls. Then no write is accepted until `ce_n_i` or `we_n_i` has been high for at least one cycle and both are low again.
- R5: When the supply goes low while the SRAM is dirty, `erase_o` is high for `ERASE_CYC` cycles and then `program_o` is high for `PROG_CYC` cycles. `store_done_o` is high only in the last program cycle.
- R6: When the supply goes low while the SRAM is clean, no erase or program phase occurs, and the block waits with `inhibit_o` high.
- R7: A save that has started always runs to completion, even if the supply returns during it. A recall follows once the supply is good.
- R8: Completing a recall or a save clears the dirty flag. Each accepted write sets it.
- R9: At most one of `erase_o`, `program_o` and `recall_o` is high at a time. `inhibit_o` is high whenever any of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_low_i | input | 1 | Asynchronous supply-below-threshold indication |
| ce_n_i | input | 1 | SRAM chip enable, active low |
| we_n_i | input | 1 | SRAM write enable, active low |
| erase_o | output | 1 | Shadow array erase phase active |
| program_o | output | 1 | Shadow array program phase active |
| recall_o | output | 1 | Recall from shadow array active |
| store_done_o | output | 1 | Pulse in the last program cycle |
| recall_done_o | output | 1 | Pulse in the last recall cycle |
| inhibit_o | output | 1 | SRAM access blocked |
| wr_en_o | output | 1 | Qualified SRAM write strobe |

## Verification
The bench builds the controller with `ERASE_CYC`=3, `PROG_CYC`=5 and `RECALL_CYC`=4. With these short phases, complete power-down and power-up sequences fit in a few dozen cycles. That brings several situations within reach: a save interrupted by an early supply return, a skipped save on a clean array, and write re-arming right at the end of a recall. A scoreboard measures the length of every phase run and compares it with the queued expectation.

// File: rtl/nvx_pkg.sv
package nvx_pkg;
  typedef enum logic [2:0] {
    ST_WAIT   = 3'd0,
    ST_RECALL = 3'd1,
    ST_IDLE   = 3'd2,
    ST_ERASE  = 3'd3,
    ST_PROG   = 3'd4
  } nvx_state_e;
endpackage

// File: rtl/nvx_sync.sv
module nvx_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/nvx_wr_qual.sv
module nvx_wr_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_i,
  input  logic we_n_i,
  input  logic inhibit_i,
  input  logic clr_i,
  output logic wr_en_o,
  output logic dirty_o
);
  logic wr_act;
  logic armed_q, armed_d;
  logic dirty_q, dirty_d;

  assign wr_act = !ce_n_i && !we_n_i;

  always_comb begin
    armed_d = armed_q;
    if (!wr_act)        armed_d = 1'b1;
    else if (inhibit_i) armed_d = 1'b0;
  end

  assign wr_en_o = !inhibit_i && wr_act && armed_q;

  always_comb begin
    dirty_d = dirty_q;
    if (clr_i)        dirty_d = 1'b0;
    else if (wr_en_o) dirty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      dirty_q <= dirty_d;
    end
  end

  assign dirty_o = dirty_q;

  p_no_write_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |-> !wr_en_o);
  p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(inhibit_i) && $past(wr_act) && wr_act) |-> !wr_en_o);
  p_dirty_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> dirty_o);
endmodule

// File: rtl/nvx_seq.sv
module nvx_seq
  import nvx_pkg::*;
#(
  parameter int ERASE_CYC  = 200,
  parameter int PROG_CYC   = 800,
  parameter int RECALL_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low_i,
  input  logic dirty_i,
  output logic inhibit_o,
  output logic erase_o,
  output logic program_o,
  output logic recall_o,
  output logic store_done_o,
  output logic recall_done_o
);
  localparam int MAX_EP = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int MAXC   = (MAX_EP > RECALL_CYC) ? MAX_EP : RECALL_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  nvx_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, ld_val;
  logic          cnt_ld, cnt_en, last;

  assign last   = (cnt_q == '0);
  assign cnt_en = cnt_ld || !last;

  always_comb begin
    st_d   = st_q;
    cnt_ld = 1'b0;
    ld_val = '0;
    case (st_q)
      ST_WAIT: if (!supply_low_i) begin
        st_d = ST_RECALL; cnt_ld = 1'b1; ld_val = CW'(RECALL_CYC - 1);
      end
      ST_RECALL: if (last) st_d = ST_IDLE;
      ST_IDLE: if (supply_low_i) begin
        if (dirty_i) begin
          st_d = ST_ERASE; cnt_ld = 1'b1; ld_val = CW'(ERASE_CYC - 1);
        end else begin
          st_d = ST_WAIT;
        end
      end
      ST_ERASE: if (last) begin
        st_d = ST_PROG; cnt_ld = 1'b1; ld_val = CW'(PROG_CYC - 1);
      end
      ST_PROG: if (last) st_d = ST_WAIT;
      default: st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAIT;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_ld ? ld_val : cnt_q - 1'b1;
    end
  end

  assign inhibit_o     = (st_q != ST_IDLE);
  assign erase_o       = (st_q == ST_ERASE);
  assign program_o     = (st_q == ST_PROG);
  assign recall_o      = (st_q == ST_RECALL);
  assign store_done_o  = program_o && last;
  assign recall_done_o = recall_o && last;

  p_erase_to_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_o) |-> program_o);
  p_no_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_o |=> (erase_o || program_o));
  p_clean_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inhibit_o && supply_low_i && !dirty_i) |=> !erase_o);
  p_done_in_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_done_o |=> !program_o);
endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl #(
  parameter int ERASE_CYC  = 200,
  parameter int PROG_CYC   = 800,
  parameter int RECALL_CYC = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low_i,
  input  logic ce_n_i,
  input  logic we_n_i,
  output logic erase_o,
  output logic program_o,
  output logic recall_o,
  output logic store_done_o,
  output logic recall_done_o,
  output logic inhibit_o,
  output logic wr_en_o
);
  logic low_s, dirty, clr;

  nvx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(supply_low_i), .q_o(low_s)
  );

  nvx_wr_qual u_wq (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .we_n_i(we_n_i),
    .inhibit_i(inhibit_o), .clr_i(clr), .wr_en_o(wr_en_o), .dirty_o(dirty)
  );

  assign clr = store_done_o || recall_done_o;

  nvx_seq #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .RECALL_CYC(RECALL_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .supply_low_i(low_s), .dirty_i(dirty || wr_en_o),
    .inhibit_o(inhibit_o), .erase_o(erase_o), .program_o(program_o),
    .recall_o(recall_o), .store_done_o(store_done_o), .recall_done_o(recall_done_o)
  );

  p_phase_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_o, program_o, recall_o}));
  p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_o || program_o || recall_o) |-> inhibit_o);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !u_wq.dirty_o);
endmodule

// File: tb/sim_nv_xfer_ctrl.sv
module sim_nv_xfer_ctrl;
  localparam int EC = 3, PC = 5, RC = 4;
  localparam int K_ERASE = 0, K_PROG = 1, K_RECALL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_low_i = 1'b1, ce_n_i = 1'b1, we_n_i = 1'b1;
  logic erase_o, program_o, recall_o, store_done_o, recall_done_o, inhibit_o, wr_en_o;

  always #10 clk = ~clk;

  nv_xfer_ctrl #(.ERASE_CYC(EC), .PROG_CYC(PC), .RECALL_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_low_i(supply_low_i), .ce_n_i(ce_n_i), .we_n_i(we_n_i),
    .erase_o(erase_o), .program_o(program_o), .recall_o(recall_o),
    .store_done_o(store_done_o), .recall_done_o(recall_done_o),
    .inhibit_o(inhibit_o), .wr_en_o(wr_en_o)
  );

  typedef struct { int kind; int len; } tok_t;
  tok_t exp_q[$];
  int n_run = 0, n_fail = 0;
  int run_len[3], done_cnt[3];
  logic last_done[3];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_run(input int kind, input int len);
    tok_t t;
    t.kind = kind; t.len = len;
    exp_q.push_back(t);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: measures phase runs and compares them with the queue
  always @(negedge clk) begin
    logic [2:0] act, dn;
    if (rst_n) begin
      act = {recall_o, program_o, erase_o};
      dn  = {recall_done_o, store_done_o, 1'b0};
      for (int k = 0; k < 3; k++) begin
        if (act[k]) begin
          run_len[k]++;
          if (dn[k]) done_cnt[k]++;
          last_done[k] = dn[k];
        end else if (run_len[k] > 0) begin
          bit ok;
          string req;
          req = (k == K_RECALL) ? "R2 recall run" : "R5 store phase run";
          if (exp_q.size() == 0) begin
            chk(1'b0, {req, " unexpected"}, k, -1);
          end else begin
            tok_t t;
            t = exp_q.pop_front();
            ok = (t.kind == k) && (t.len == run_len[k]) &&
                 (k == K_ERASE || (done_cnt[k] == 1 && last_done[k]));
            chk(ok, req, run_len[k] * 10 + k, t.len * 10 + t.kind);
          end
          run_len[k] = 0; done_cnt[k] = 0; last_done[k] = 1'b0;
        end
      end
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin run_len[k] = 0; done_cnt[k] = 0; last_done[k] = 1'b0; end
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk(inhibit_o && !recall_o && !erase_o && !wr_en_o, "R1 reset state", inhibit_o, 1);

    // Power-up recall with strobes held active across its end
    expect_run(K_RECALL, RC);
    supply_low_i = 1'b0;
    tick(2);
    chk(!recall_o, "R1 sync latency early", recall_o, 0);
    tick(1);
    chk(recall_o && inhibit_o, "R2 recall with inhibit", recall_o, 1);
    ce_n_i = 1'b0; we_n_i = 1'b0;
    for (int i = 0; i < 20 && inhibit_o; i++) tick(1);
    chk(!wr_en_o, "R4 held strobe ignored", wr_en_o, 0);
    tick(1);
    chk(!wr_en_o, "R4 still ignored", wr_en_o, 0);
    we_n_i = 1'b1;
    tick(1);
    chk(!wr_en_o, "R3 strobe inactive", wr_en_o, 0);
    we_n_i = 1'b0;
    tick(1);
    chk(wr_en_o, "R4 re-toggled write accepted", wr_en_o, 1);
    we_n_i = 1'b1; ce_n_i = 1'b1;

    // Dirty power-down store
    expect_run(K_ERASE, EC);
    expect_run(K_PROG, PC);
    supply_low_i = 1'b1;
    tick(3);
    chk(erase_o, "R5 erase starts", erase_o, 1);
    tick(10);
    chk(!erase_o && !program_o && inhibit_o, "R5 store ended, waiting", inhibit_o, 1);

    // Power-up recall clears dirty
    expect_run(K_RECALL, RC);
    supply_low_i = 1'b0;
    tick(8);
    chk(!inhibit_o, "R8 idle after recall", inhibit_o, 0);

    // Clean power-down: store skipped
    supply_low_i = 1'b1;
    tick(6);
    chk(!erase_o && !program_o && inhibit_o, "R6 clean store skipped", erase_o, 0);
    expect_run(K_RECALL, RC);
    supply_low_i = 1'b0;
    tick(8);
    chk(!inhibit_o, "R8 idle again", inhibit_o, 0);

    // Normal write in idle
    ce_n_i = 1'b0; we_n_i = 1'b0;
    tick(1);
    chk(wr_en_o, "R3 idle write", wr_en_o, 1);
    ce_n_i = 1'b1; we_n_i = 1'b1;

    // Store not aborted by early supply return
    expect_run(K_ERASE, EC);
    expect_run(K_PROG, PC);
    expect_run(K_RECALL, RC);
    supply_low_i = 1'b1;
    tick(4);
    chk(erase_o, "R7 in erase", erase_o, 1);
    supply_low_i = 1'b0;
    tick(3);
    ce_n_i = 1'b0; we_n_i = 1'b0;
    tick(1);
    chk(program_o && !wr_en_o, "R7 program continues, R3 write blocked", wr_en_o, 0);
    ce_n_i = 1'b1; we_n_i = 1'b1;
    tick(12);
    chk(!inhibit_o, "R7 recall followed store", inhibit_o, 0);
    chk(exp_q.size() == 0, "R2 all runs seen", exp_q.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule